// File: doc/BRIEF.md
# Analog Memory Cell Allocator

This block hands out write addresses for a 64-cell circular analog sample memory in a detector front end. Every beam clock it names one cell to be written, stepping upward through the ring and skipping any cell that still holds samples awaiting digitisation. When a level-1 trigger arrives, the block looks back into its record of recently written cells. It picks the four consecutive cells that hold the triggered pulse, written between 43 and 40 beam clocks earlier. It locks those cells out of the ring, appends the event to an event list kept in trigger order, and queues the four cell addresses for the converter.

The converter reads cell addresses from the conversion list. When it has finished and stored the oldest event, it pulses `conv_done`. That event leaves the event list, and its cells return to the ring. Triggers can come close enough together that two events share cells. A shared cell keeps a reference count, so it returns to the ring only when the last event that names it has been released. At most five events may be pending. A trigger that arrives while the block is busy is dropped.

Top module: `acell_allocator`

## Requirements
- R1: After reset, `wr_cell` is 0, `conv_empty` is 1, and `evt_valid` and `busy` are 0. With no locks in place, `wr_cell` then steps 1, 2, 3, ... on each clock. The history is preloaded as if cell 63 was written one clock before the first cycle, cell 62 two clocks before, and so on.
- R2: On every clock, `wr_cell` moves to the next higher address, modulo 64, whose cell is not locked. It never shows a locked cell.
- R3: A trigger accepted in cycle t captures an event whose sample j (j = 0..3) is the cell shown on `wr_cell` in cycle t-43+j. Sample j occupies bits [6j+5:6j] of `evt_cells`.
- R4: An accepted trigger appends its four cells to the conversion list, sample 0 first. `conv_cell` shows the oldest entry whenever `conv_empty` is 0. `conv_rd` removes that entry, and `conv_rd` on an empty list is ignored.
- R5: The cells of a pending event are never written. After `conv_done` releases the event, its cells are written again on the ring's next pass.
- R6: `evt_cells` with `evt_valid` shows the oldest pending event. `conv_done` releases that event and exposes the next one in trigger order. `conv_done` with no pending event is ignored.
- R7: A cell named by two pending events stays locked until both events have been released.
- R8: `busy` is 1 while five events are pending, or while the conversion list holds more than 16 entries. A trigger seen while `busy` is 1 creates no event, queues no cells and locks nothing.
- All results of inputs sampled at a clock edge are visible after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beam clock, one cell written per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl1_trig | input | 1 | Level-1 trigger, one cycle per trigger |
| conv_done | input | 1 | Oldest pending event converted and stored |
| conv_rd | input | 1 | Remove the head of the conversion list |
| wr_cell | output | 6 | Cell to be written this beam clock |
| busy | output | 1 | Triggers are being dropped |
| conv_empty | output | 1 | Conversion list holds no entry |
| conv_cell | output | 6 | Head of the conversion list |
| evt_valid | output | 1 | At least one event pending |
| evt_cells | output | 24 | Four sample cells of the oldest pending event |

## Verification
Every result is registered. The effect of a trigger, a release or a read sampled at clock edge n appears on the outputs right after edge n, and the next `wr_cell` already accounts for locks taken or dropped at that edge. The bench drives inputs on the falling edge, updates its behavioural model at the rising edge, and compares all outputs on the following falling edge. Each result is therefore checked in the first cycle it is due. Lock behaviour is checked over whole ring passes, by recording which cells appear on `wr_cell` while an event is pending and after it is released.

// File: rtl/acell_pkg.sv
`timescale 1ns/1ps
package acell_pkg;
   localparam int DEF_CELLS      = 64;
   localparam int DEF_SAMPLES    = 4;
   localparam int DEF_MAX_EVENTS = 5;
   localparam int DEF_LOOKBACK   = 40;

   // wrap an index into a ring of the given depth
   function automatic int ring_add(input int base, input int step, input int depth);
      int s;
      s = base + step;
      if (s >= depth) s = s - depth;
      return s;
   endfunction
endpackage

// File: rtl/acell_history.sv
`timescale 1ns/1ps
module acell_history #(
   parameter int CELLS = 64,
   parameter int AW    = 6,
   parameter int DEPTH = 43
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       wr_cell,
   output logic [DEPTH*AW-1:0] taps
);
   // taps entry k holds the cell written k+1 clocks ago
   logic [DEPTH*AW-1:0] hist_q;

   generate
      if (DEPTH >= CELLS) begin : g_bad_depth
         $error("history deeper than the cell ring");
      end
      if (DEPTH > 1) begin : g_shift_long
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) hist_q[k*AW +: AW] <= AW'(CELLS-1-k);
            end else begin
               hist_q <= {hist_q[(DEPTH-1)*AW-1:0], wr_cell};
            end
         end
      end else begin : g_shift_one
         always_ff @(posedge clk) begin
            if (!rst_n) hist_q <= AW'(CELLS-1);
            else        hist_q <= wr_cell;
         end
      end
   endgenerate

   assign taps = hist_q;
endmodule

// File: rtl/acell_lock_table.sv
`timescale 1ns/1ps
module acell_lock_table #(
   parameter int CELLS   = 64,
   parameter int AW      = 6,
   parameter int SAMPLES = 4,
   parameter int MAX_REF = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acq,
   input  logic [SAMPLES*AW-1:0] acq_cells,
   input  logic                  rel,
   input  logic [SAMPLES*AW-1:0] rel_cells,
   output logic [AW-1:0]         wr_cell
);
   localparam int RW = $clog2(MAX_REF+1);

   logic [CELLS-1:0] locked_q;
   logic [CELLS-1:0] locked_nxt;
   logic [AW-1:0]    wr_q;
   logic [AW-1:0]    wr_nxt;

   generate
      if (CELLS != (1 << AW)) begin : g_bad_ring
         $error("cell count must be a power of two matching the address width");
      end
      for (genvar c = 0; c < CELLS; c++) begin : g_cell
         logic [RW-1:0] cnt_q;
         logic [RW-1:0] cnt_nxt;
         logic          hit_acq;
         logic          hit_rel;

         always_comb begin
            hit_acq = 1'b0;
            hit_rel = 1'b0;
            for (int j = 0; j < SAMPLES; j++) begin
               hit_acq = hit_acq | (acq && (acq_cells[j*AW +: AW] == AW'(c)));
               hit_rel = hit_rel | (rel && (rel_cells[j*AW +: AW] == AW'(c)));
            end
         end

         always_comb begin
            cnt_nxt = cnt_q;
            if (hit_acq && !hit_rel)      cnt_nxt = cnt_q + RW'(1);
            else if (!hit_acq && hit_rel) cnt_nxt = cnt_q - RW'(1);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_nxt;
         end

         assign locked_q[c]   = (cnt_q != '0);
         assign locked_nxt[c] = (cnt_nxt != '0);

         // R7: a shared cell never counts beyond the events that may hold it
         assert_ref_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= RW'(MAX_REF));
         // R7: a release never hits a cell that no event holds
         assert_release_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hit_rel |-> (cnt_q != '0));
      end
   endgenerate

   // next free cell above the current one, searched against the updated locks
   always_comb begin
      logic [AW-1:0] idx;
      wr_nxt = wr_q;
      for (int i = CELLS-1; i >= 1; i--) begin
         idx = wr_q + AW'(i);
         if (!locked_nxt[idx]) wr_nxt = idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wr_q <= '0;
      else        wr_q <= wr_nxt;
   end

   assign wr_cell = wr_q;

   // R2: the cell offered for writing is never held by an event
   assert_write_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !locked_q[wr_q]);
   // R2: the write position moves every beam clock
   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wr_q != $past(wr_q)));
endmodule

// File: rtl/acell_event_queue.sv
`timescale 1ns/1ps
module acell_event_queue #(
   parameter int W     = 24,
   parameter int DEPTH = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   input  logic                       pop,
   output logic [W-1:0]               head,
   output logic                       valid,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rp_q, wp_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp_q  <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= bump(wp_q);
         if (pop)  rp_q <= bump(rp_q);
         if (push && !pop)      cnt_q <= cnt_q + CW'(1);
         else if (!push && pop) cnt_q <= cnt_q - CW'(1);
      end
   end

   assign head  = mem[rp_q];
   assign valid = (cnt_q != '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign count = cnt_q;

   // R8: no event is stored once the list is full
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R6: a release with no new event shortens the list by one
   assert_release_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/acell_conv_fifo.sv
`timescale 1ns/1ps
module acell_conv_fifo #(
   parameter int AW    = 6,
   parameter int NPUSH = 4,
   parameter int DEPTH = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [NPUSH*AW-1:0] push_cells,
   input  logic                pop,
   output logic [AW-1:0]       head,
   output logic                empty,
   output logic                room
);
   import acell_pkg::*;
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] rp_q, wp_q;
   logic [CW-1:0] cnt_q;

   generate
      if (NPUSH > DEPTH) begin : g_bad_fifo
         $error("conversion list shallower than one event");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         for (int j = 0; j < NPUSH; j++)
            mem[PW'(ring_add(int'(wp_q), j, DEPTH))] <= push_cells[j*AW +: AW];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp_q  <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= PW'(ring_add(int'(wp_q), NPUSH, DEPTH));
         if (pop)  rp_q <= PW'(ring_add(int'(rp_q), 1, DEPTH));
         cnt_q <= cnt_q + (push ? CW'(NPUSH) : CW'(0)) - (pop ? CW'(1) : CW'(0));
      end
   end

   assign head  = mem[rp_q];
   assign empty = (cnt_q == '0);
   assign room  = (cnt_q <= CW'(DEPTH-NPUSH));

   // R4: a whole event always fits when it is queued
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q <= CW'(DEPTH-NPUSH)));
   // R4: removal only happens from a non-empty list
   assert_pop_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R4: a read with no new event shortens the list by one
   assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/acell_allocator.sv
`timescale 1ns/1ps
module acell_allocator #(
   parameter int CELLS      = acell_pkg::DEF_CELLS,
   parameter int SAMPLES    = acell_pkg::DEF_SAMPLES,
   parameter int MAX_EVENTS = acell_pkg::DEF_MAX_EVENTS,
   parameter int LOOKBACK   = acell_pkg::DEF_LOOKBACK,
   parameter int AW         = $clog2(CELLS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lvl1_trig,
   input  logic                  conv_done,
   input  logic                  conv_rd,
   output logic [AW-1:0]         wr_cell,
   output logic                  busy,
   output logic                  conv_empty,
   output logic [AW-1:0]         conv_cell,
   output logic                  evt_valid,
   output logic [SAMPLES*AW-1:0] evt_cells
);
   localparam int HIST  = LOOKBACK + SAMPLES - 1;
   localparam int FDEP  = MAX_EVENTS * SAMPLES;
   localparam int EW    = SAMPLES * AW;
   localparam int ECW   = $clog2(MAX_EVENTS+1);

   generate
      if (LOOKBACK < 1 || SAMPLES < 1 || MAX_EVENTS < 1) begin : g_bad_cfg
         $error("look-back, sample and event counts must be positive");
      end
      if (CELLS - FDEP <= HIST) begin : g_bad_margin
         $error("free cells cannot cover the look-back window");
      end
   endgenerate

   logic [HIST*AW-1:0] taps;
   logic [EW-1:0]      sel_cells;
   logic               accept, release_evt, rd_ok;
   logic               evt_full, fifo_room;
   logic [ECW-1:0]     evt_count;

   acell_history #(.CELLS(CELLS), .AW(AW), .DEPTH(HIST)) u_history (
      .clk(clk), .rst_n(rst_n), .wr_cell(wr_cell), .taps(taps));

   // sample j is the cell written LOOKBACK+SAMPLES-1-j clocks before the trigger
   generate
      for (genvar j = 0; j < SAMPLES; j++) begin : g_pick
         assign sel_cells[j*AW +: AW] = taps[(HIST-1-j)*AW +: AW];
      end
   endgenerate

   assign busy        = evt_full || !fifo_room;
   assign accept      = lvl1_trig && !busy;
   assign release_evt = conv_done && evt_valid;
   assign rd_ok       = conv_rd && !conv_empty;

   acell_lock_table #(.CELLS(CELLS), .AW(AW), .SAMPLES(SAMPLES), .MAX_REF(MAX_EVENTS)) u_locks (
      .clk(clk), .rst_n(rst_n),
      .acq(accept), .acq_cells(sel_cells),
      .rel(release_evt), .rel_cells(evt_cells),
      .wr_cell(wr_cell));

   acell_event_queue #(.W(EW), .DEPTH(MAX_EVENTS)) u_events (
      .clk(clk), .rst_n(rst_n),
      .push(accept), .push_data(sel_cells), .pop(release_evt),
      .head(evt_cells), .valid(evt_valid), .full(evt_full), .count(evt_count));

   acell_conv_fifo #(.AW(AW), .NPUSH(SAMPLES), .DEPTH(FDEP)) u_conv (
      .clk(clk), .rst_n(rst_n),
      .push(accept), .push_cells(sel_cells), .pop(rd_ok),
      .head(conv_cell), .empty(conv_empty), .room(fifo_room));

   // R8: a dropped trigger leaves the event list untouched
   assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl1_trig && busy && !release_evt) |=> $stable(evt_count));
   // R6: a release with no pending event leaves the list empty
   assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !evt_valid && !lvl1_trig) |=> !evt_valid);
endmodule

// File: tb/acell_allocator_bench.sv
`timescale 1ns/1ps
module acell_allocator_bench;
   typedef logic [23:0] ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0, done = 1'b0, rd = 1'b0;
   logic [5:0]  wr_cell, conv_cell;
   logic        busy, conv_empty, evt_valid;
   logic [23:0] evt_cells;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int  m_cnt [64];
   int  m_hist[$];
   int  m_wr;
   ev_t m_evq[$];
   int  m_fq[$];
   bit [63:0] seen;

   always #2.5 clk = ~clk;

   acell_allocator u_acell_allocator (
      .clk(clk), .rst_n(rst_n), .lvl1_trig(trig), .conv_done(done), .conv_rd(rd),
      .wr_cell(wr_cell), .busy(busy), .conv_empty(conv_empty), .conv_cell(conv_cell),
      .evt_valid(evt_valid), .evt_cells(evt_cells));

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_hist.delete(); m_evq.delete(); m_fq.delete();
      for (int k = 0; k < 43; k++) m_hist.push_back(63 - k);
      for (int c = 0; c < 64; c++) m_cnt[c] = 0;
      m_wr = 0;
   endtask

   task automatic model_step(input bit t, input bit d, input bit r);
      bit  busy_m, rel, acc;
      ev_t sel, e;
      busy_m = (m_evq.size() == 5) || (m_fq.size() > 16);
      rel = d && (m_evq.size() > 0);
      acc = t && !busy_m;
      for (int j = 0; j < 4; j++) sel[j*6 +: 6] = 6'(m_hist[42 - j]);
      if (r && m_fq.size() > 0) void'(m_fq.pop_front());
      if (rel) begin
         e = m_evq.pop_front();
         for (int j = 0; j < 4; j++) m_cnt[e[j*6 +: 6]]--;
      end
      if (acc) begin
         for (int j = 0; j < 4; j++) begin
            m_cnt[sel[j*6 +: 6]]++;
            m_fq.push_back(int'(sel[j*6 +: 6]));
         end
         m_evq.push_back(sel);
      end
      m_hist.push_front(m_wr);
      void'(m_hist.pop_back());
      for (int i = 1; i < 64; i++) begin
         if (m_cnt[(m_wr + i) % 64] == 0) begin
            m_wr = (m_wr + i) % 64;
            break;
         end
      end
   endtask

   task automatic compare();
      check(wr_cell == 6'(m_wr), "R2 R5 R7 wr_cell", wr_cell, m_wr);
      check(busy == ((m_evq.size() == 5) || (m_fq.size() > 16)), "R8 busy", busy,
            (m_evq.size() == 5) || (m_fq.size() > 16));
      check(conv_empty == (m_fq.size() == 0), "R4 conv_empty", conv_empty, m_fq.size() == 0);
      if (m_fq.size() > 0) check(conv_cell == 6'(m_fq[0]), "R4 conv_cell", conv_cell, m_fq[0]);
      check(evt_valid == (m_evq.size() > 0), "R6 evt_valid", evt_valid, m_evq.size() > 0);
      if (m_evq.size() > 0) check(evt_cells == m_evq[0], "R3 R6 evt_cells", evt_cells, m_evq[0]);
      seen[wr_cell] = 1'b1;
   endtask

   task automatic step(input bit t, input bit d, input bit r);
      trig = t; done = d; rd = r;
      @(posedge clk);
      model_step(t, d, r);
      @(negedge clk);
      compare();
      trig = 1'b0; done = 1'b0; rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
   endtask

   task automatic drain();
      while (m_evq.size() > 0 || m_fq.size() > 0)
         step(1'b0, m_evq.size() > 0, m_fq.size() > 0);
   endtask

   initial begin
      ev_t a_ev, b_ev;
      int  shared0, shared1, nrel, nrd;
      logic [15:0] lfsr;

      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(wr_cell == 6'd0, "R1 reset wr_cell", wr_cell, 0);
      check(conv_empty == 1'b1, "R1 reset conv_empty", conv_empty, 1);
      check(evt_valid == 1'b0, "R1 reset evt_valid", evt_valid, 0);
      check(busy == 1'b0, "R1 reset busy", busy, 0);

      // R3: trigger in the first cycle picks cells 21..24 from the preloaded history
      step(1'b1, 1'b0, 1'b0);
      check(evt_cells == {6'd24, 6'd23, 6'd22, 6'd21}, "R3 first event cells", evt_cells,
            {6'd24, 6'd23, 6'd22, 6'd21});
      check(wr_cell == 6'd1, "R1 write sequence", wr_cell, 1);
      check(conv_cell == 6'd21, "R4 oldest sample first", conv_cell, 21);

      // R5: locked cells are skipped for a full pass, then reused after release
      seen = '0;
      idle(80);
      check(seen[24:21] == 4'b0000, "R5 locked cells not written", seen[24:21], 0);
      step(1'b0, 1'b1, 1'b0);
      drain();
      seen = '0;
      idle(80);
      check(seen[24:21] == 4'b1111, "R5 released cells reused", seen[24:21], 15);

      // R7: overlapping events share two cells
      step(1'b1, 1'b0, 1'b0);
      a_ev = m_evq[0];
      step(1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      b_ev = m_evq[1];
      shared0 = a_ev[12 +: 6];
      shared1 = a_ev[18 +: 6];
      check(b_ev[5:0] == 6'(shared0), "R7 overlap shares cell", b_ev[5:0], shared0);
      step(1'b0, 1'b1, 1'b0);
      check(evt_cells == b_ev, "R6 next event in order", evt_cells, b_ev);
      seen = '0;
      idle(80);
      check(seen[shared0] == 1'b0 && seen[shared1] == 1'b0, "R7 shared kept locked",
            seen[shared0] | seen[shared1], 0);
      check(seen[a_ev[5:0]] == 1'b1, "R7 unshared cell freed", seen[a_ev[5:0]], 1);
      step(1'b0, 1'b1, 1'b0);
      seen = '0;
      idle(80);
      check(seen[shared0] == 1'b1 && seen[shared1] == 1'b1, "R7 shared freed last",
            seen[shared0] & seen[shared1], 1);
      drain();

      // R6 / R4: release and read with nothing pending are ignored
      step(1'b0, 1'b1, 1'b1);
      check(evt_valid == 1'b0 && conv_empty == 1'b1, "R6 idle release ignored", evt_valid, 0);
      step(1'b1, 1'b0, 1'b0);
      check(conv_cell == evt_cells[5:0], "R4 head after idle read", conv_cell, evt_cells[5:0]);
      drain();

      // R8: five events fill the block, a sixth trigger is dropped
      for (int e = 0; e < 5; e++) begin
         step(1'b1, 1'b0, 1'b0);
         idle(3);
      end
      check(busy == 1'b1, "R8 busy when full", busy, 1);
      step(1'b1, 1'b0, 1'b0);
      nrel = 0;
      while (evt_valid && nrel < 10) begin
         step(1'b0, 1'b1, 1'b0);
         nrel++;
      end
      check(nrel == 5, "R8 dropped trigger made no event", nrel, 5);
      nrd = 0;
      while (!conv_empty && nrd < 30) begin
         step(1'b0, 1'b0, 1'b1);
         nrd++;
      end
      check(nrd == 20, "R4 R8 list length", nrd, 20);

      // mixed traffic against the model
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[2:0] == 3'd0, lfsr[7:4] == 4'd3, lfsr[9]);
      end
      drain();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule